// File: doc/BRIEF.md
# I2C Bus Clock Phase Timer with Input Deglitcher

This block produces the serial-clock waveform of an I2C controller and the point in each low phase at which the data line may change. Three pairs of high and low counts, one pair per speed mode, are held on its inputs. A two-bit mode code picks the pair in use. While `run` is high the block alternates low and high phases on `scl_out`, where 1 releases the line and 0 pulls it low. It marks the start of each low phase and the start of each counted high phase with one-cycle strobes. After a programmed number of clocks from each falling edge it pulses `sda_chg_stb`.

Both bus inputs pass through a two-flop synchronizer and a spike filter. The filter length is set by `spike_len`. Filtered SCL closes the loop: the high-phase count starts only once the line is seen high, so a target that holds SCL low lengthens the high phase. The internal overhead in the high phase comes from this filter path, so it grows with the spike length.

Top module: `i2c_scl_timer`

## Requirements
- R1: `speed_mode` selects the count pair: 0 standard (`std_hi`/`std_lo`), 1 fast (`fast_hi`/`fast_lo`), 2 high speed (`hs_hi`/`hs_lo`). Code 3 behaves exactly as code 0.
- R2: Every low phase of `scl_out` lasts the selected low count plus 1 clocks. Counts are valid when the low count is at least `spike_len`+2.
- R3: With `scl_in` following `scl_out`, every high phase of `scl_out` lasts the selected high count plus `spike_len` plus 7 clocks.
- R4: If a target holds `scl_in` low for S clocks after `scl_out` is released, the high phase grows by S clocks. `scl_high_stb` pulses only when the previously sampled filtered SCL was high.
- R5: A low pulse on a bus input lasting `spike_len` clocks or fewer leaves the filtered output unchanged. A pulse of `spike_len`+1 clocks or more is passed.
- R6: A level change applied just before clock edge k appears on the filtered output at edge k+2+`spike_len`. With `spike_len`=0 only the two synchronizer stages delay it.
- R7: `sda_chg_stb` is a one-cycle pulse that rises on the edge `sda_hold_cnt`+1 clocks after the edge on which `scl_out` falls.
- R8: While `rst` is high and on the following cycle, `scl_out` is 1, all strobes are 0 and both filtered outputs are 1.
- R9: With `run` low, a released `scl_out` stays released. Once `run` drops, the current high phase ends without a further falling edge.
- R10: `scl_fall_stb` is high exactly in the cycles in which `scl_out` has just gone from 1 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run | input | 1 | Keep generating clock periods |
| speed_mode | input | 2 | 0 standard, 1 fast, 2 high speed, 3 standard |
| std_hi | input | CNT_W | Standard-mode high count |
| std_lo | input | CNT_W | Standard-mode low count |
| fast_hi | input | CNT_W | Fast-mode high count |
| fast_lo | input | CNT_W | Fast-mode low count |
| hs_hi | input | CNT_W | High-speed high count |
| hs_lo | input | CNT_W | High-speed low count |
| sda_hold_cnt | input | HOLD_W | Clocks from SCL fall to the data-change strobe, minus one |
| spike_len | input | SPK_W | Longest suppressed glitch, in clocks |
| scl_in | input | 1 | Sampled SCL line |
| sda_in | input | 1 | Sampled SDA line |
| scl_out | output | 1 | SCL drive: 1 released, 0 pulled low |
| scl_fall_stb | output | 1 | Low phase has just begun |
| scl_high_stb | output | 1 | High-phase count has just begun |
| sda_chg_stb | output | 1 | Data line may change now |
| scl_filt | output | 1 | Synchronized, deglitched SCL |
| sda_filt | output | 1 | Synchronized, deglitched SDA |

## Verification
The clock generator is run in every mode code, including code 3, with distinct count pairs per mode. A wrong mux leg therefore shows up as a wrong phase length, not a matching one. Spike lengths of 0, 1, 2 and 5 separate the fixed overhead from the filter-dependent part of the high phase. A stretched run, where the target holds SCL low, separates counting from the release edge from counting from the observed high level. Data-line glitches of exactly `spike_len` and `spike_len`+1 clocks, plus an edge-latency probe, pin the filter threshold and its delay. Hold counts from 0 to 4 test the hold timer's off-by-one.

// File: rtl/i2c_tmg_pkg.sv
package i2c_tmg_pkg;
  typedef enum logic [1:0] {PH_IDLE, PH_LOW, PH_WAIT, PH_HIGH} phase_e;

  localparam logic [1:0] MODE_STD  = 2'd0;
  localparam logic [1:0] MODE_FAST = 2'd1;
  localparam logic [1:0] MODE_HS   = 2'd2;
endpackage

// File: rtl/i2c_tmg_filter.sv
// Two-flop synchronizer followed by a stability filter: a new level is
// accepted once it has differed from the output for spike_len+1 clocks.
module i2c_tmg_filter #(
  parameter int SPK_W = 8,
  parameter logic RST_VAL = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SPK_W-1:0] spike_len,
  input  logic             din,
  output logic             dout
);
  logic             sync1, sync2;
  logic [SPK_W-1:0] run_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync1   <= RST_VAL;
      sync2   <= RST_VAL;
      dout    <= RST_VAL;
      run_cnt <= '0;
    end else begin
      sync1 <= din;
      sync2 <= sync1;
      if (sync2 == dout) begin
        run_cnt <= '0;
      end else if (run_cnt == spike_len) begin
        dout    <= sync2;
        run_cnt <= '0;
      end else begin
        run_cnt <= run_cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/i2c_tmg_phase.sv
// SCL phase sequencer: low phase counted from the falling edge, high phase
// counted only after filtered SCL reads high (clock stretching).
module i2c_tmg_phase
  import i2c_tmg_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [CNT_W-1:0] hi_cnt,
  input  logic [CNT_W-1:0] lo_cnt,
  input  logic             scl_filt,
  output logic             scl_out,
  output logic             fall_stb,
  output logic             high_stb
);
  localparam int PW = CNT_W + 1;
  // Clocks of the high phase already spent in the output-to-filter loop
  // are covered by the wait state; two more come from the load and the
  // terminal cycle of the count.
  localparam logic [PW-1:0] HI_ADJ = PW'(2);

  phase_e        state;
  logic [PW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= PH_IDLE;
      cnt      <= '0;
      scl_out  <= 1'b1;
      fall_stb <= 1'b0;
      high_stb <= 1'b0;
    end else begin
      fall_stb <= 1'b0;
      high_stb <= 1'b0;
      case (state)
        PH_IDLE: begin
          if (run) begin
            state    <= PH_LOW;
            scl_out  <= 1'b0;
            cnt      <= {1'b0, lo_cnt};
            fall_stb <= 1'b1;
          end
        end
        PH_LOW: begin
          if (cnt == '0) begin
            state   <= PH_WAIT;
            scl_out <= 1'b1;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        PH_WAIT: begin
          if (scl_filt) begin
            state    <= PH_HIGH;
            cnt      <= {1'b0, hi_cnt} + HI_ADJ;
            high_stb <= 1'b1;
          end
        end
        default: begin
          if (cnt != '0) begin
            cnt <= cnt - 1'b1;
          end else if (run) begin
            state    <= PH_LOW;
            scl_out  <= 1'b0;
            cnt      <= {1'b0, lo_cnt};
            fall_stb <= 1'b1;
          end else begin
            state <= PH_IDLE;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/i2c_tmg_hold.sv
// Data-hold timer: pulses chg_stb hold_cnt+1 clocks after the SCL fall edge.
module i2c_tmg_hold #(
  parameter int HOLD_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fall_stb,
  input  logic [HOLD_W-1:0] hold_cnt,
  output logic              chg_stb
);
  logic              armed;
  logic [HOLD_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      armed   <= 1'b0;
      cnt     <= '0;
      chg_stb <= 1'b0;
    end else begin
      chg_stb <= 1'b0;
      if (fall_stb) begin
        armed   <= (hold_cnt != '0);
        cnt     <= hold_cnt - 1'b1;
        chg_stb <= (hold_cnt == '0);
      end else if (armed) begin
        if (cnt == '0) begin
          chg_stb <= 1'b1;
          armed   <= 1'b0;
        end else begin
          cnt <= cnt - 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/i2c_scl_timer.sv
module i2c_scl_timer
  import i2c_tmg_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int HOLD_W = 16,
  parameter int SPK_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic [1:0]        speed_mode,
  input  logic [CNT_W-1:0]  std_hi,
  input  logic [CNT_W-1:0]  std_lo,
  input  logic [CNT_W-1:0]  fast_hi,
  input  logic [CNT_W-1:0]  fast_lo,
  input  logic [CNT_W-1:0]  hs_hi,
  input  logic [CNT_W-1:0]  hs_lo,
  input  logic [HOLD_W-1:0] sda_hold_cnt,
  input  logic [SPK_W-1:0]  spike_len,
  input  logic              scl_in,
  input  logic              sda_in,
  output logic              scl_out,
  output logic              scl_fall_stb,
  output logic              scl_high_stb,
  output logic              sda_chg_stb,
  output logic              scl_filt,
  output logic              sda_filt
);
  localparam int NLANE = 2;

  logic [NLANE-1:0] lane_raw, lane_filt;
  logic [CNT_W-1:0] sel_hi, sel_lo;

  assign lane_raw = {sda_in, scl_in};

  for (genvar g = 0; g < NLANE; g++) begin : g_lane
    i2c_tmg_filter #(.SPK_W(SPK_W), .RST_VAL(1'b1)) u_flt (
      .clk       (clk),
      .rst       (rst),
      .spike_len (spike_len),
      .din       (lane_raw[g]),
      .dout      (lane_filt[g])
    );
  end

  assign scl_filt = lane_filt[0];
  assign sda_filt = lane_filt[1];

  always_comb begin
    case (speed_mode)
      MODE_FAST: begin sel_hi = fast_hi; sel_lo = fast_lo; end
      MODE_HS:   begin sel_hi = hs_hi;   sel_lo = hs_lo;   end
      default:   begin sel_hi = std_hi;  sel_lo = std_lo;  end
    endcase
  end

  i2c_tmg_phase #(.CNT_W(CNT_W)) u_phase (
    .clk      (clk),
    .rst      (rst),
    .run      (run),
    .hi_cnt   (sel_hi),
    .lo_cnt   (sel_lo),
    .scl_filt (scl_filt),
    .scl_out  (scl_out),
    .fall_stb (scl_fall_stb),
    .high_stb (scl_high_stb)
  );

  i2c_tmg_hold #(.HOLD_W(HOLD_W)) u_hold (
    .clk      (clk),
    .rst      (rst),
    .fall_stb (scl_fall_stb),
    .hold_cnt (sda_hold_cnt),
    .chg_stb  (sda_chg_stb)
  );
endmodule

// File: rtl/i2c_scl_timer_chk.sv
module i2c_scl_timer_chk (
  input logic clk,
  input logic rst,
  input logic run,
  input logic scl_out,
  input logic scl_filt,
  input logic scl_fall_stb,
  input logic scl_high_stb,
  input logic sda_chg_stb
);
  p_fall_marked_r10: assert property (@(posedge clk) disable iff (rst)
    $fell(scl_out) |-> scl_fall_stb);

  p_mark_is_fall_r10: assert property (@(posedge clk) disable iff (rst)
    scl_fall_stb |-> (!scl_out && $past(scl_out)));

  p_high_after_filt_r4: assert property (@(posedge clk) disable iff (rst)
    scl_high_stb |-> ($past(scl_filt) && scl_out));

  p_hold_single_r7: assert property (@(posedge clk) disable iff (rst)
    sda_chg_stb |=> !sda_chg_stb);

  p_reset_idle_r8: assert property (@(posedge clk)
    rst |=> (scl_out && !scl_fall_stb && !scl_high_stb && !sda_chg_stb));

  p_stop_holds_r9: assert property (@(posedge clk) disable iff (rst)
    (!run && scl_out) |=> scl_out);
endmodule

bind i2c_scl_timer i2c_scl_timer_chk u_chk (
  .clk          (clk),
  .rst          (rst),
  .run          (run),
  .scl_out      (scl_out),
  .scl_filt     (scl_filt),
  .scl_fall_stb (scl_fall_stb),
  .scl_high_stb (scl_high_stb),
  .sda_chg_stb  (sda_chg_stb)
);

// File: tb/i2c_scl_timer_tb.sv
module i2c_scl_timer_tb;
  localparam int CNT_W = 16, HOLD_W = 16, SPK_W = 8;

  typedef struct { int kind; int len; } item_t;  // kind 0 low, 1 high, 2 hold

  logic clk = 1'b0, rst = 1'b1, run = 1'b0;
  logic [1:0] speed_mode = 2'd0;
  logic [CNT_W-1:0] std_hi = 16'd5, std_lo = 16'd7, fast_hi = 16'd3,
                    fast_lo = 16'd9, hs_hi = 16'd1, hs_lo = 16'd8;
  logic [HOLD_W-1:0] sda_hold_cnt = '0;
  logic [SPK_W-1:0]  spike_len = '0;
  logic sda_drv = 1'b1;
  logic scl_in, scl_out, scl_fall_stb, scl_high_stb, sda_chg_stb, scl_filt, sda_filt;

  int stretch_cyc = 0, stretch_cnt = 0;
  int n_chk = 0, n_bad = 0;
  item_t exp_q[$];
  string cur_tag = "R8";

  always #10 clk = ~clk;

  // Target model: holds SCL low for stretch_cyc clocks after each release.
  always @(posedge clk)
    if (!scl_out) stretch_cnt <= 0;
    else if (stretch_cnt < stretch_cyc) stretch_cnt <= stretch_cnt + 1;
  assign scl_in = scl_out && (stretch_cnt >= stretch_cyc);

  i2c_scl_timer #(.CNT_W(CNT_W), .HOLD_W(HOLD_W), .SPK_W(SPK_W)) u_dut (
    .clk(clk), .rst(rst), .run(run), .speed_mode(speed_mode),
    .std_hi(std_hi), .std_lo(std_lo), .fast_hi(fast_hi), .fast_lo(fast_lo),
    .hs_hi(hs_hi), .hs_lo(hs_lo), .sda_hold_cnt(sda_hold_cnt),
    .spike_len(spike_len), .scl_in(scl_in), .sda_in(sda_drv),
    .scl_out(scl_out), .scl_fall_stb(scl_fall_stb), .scl_high_stb(scl_high_stb),
    .sda_chg_stb(sda_chg_stb), .scl_filt(scl_filt), .sda_filt(sda_filt));

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual %0d expected %0d", tag, act, expv);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
  endtask

  task automatic record(input int kind, input int len);
    item_t e;
    if (exp_q.size() == 0) return;
    e = exp_q.pop_front();
    chk(e.kind == kind && e.len == len,
        $sformatf("%s kind %0d/%0d (R2 low, R3 high, R7 hold)", cur_tag, kind, e.kind),
        len, e.len);
  endtask

  // Monitor: measures phase lengths and hold delay at negedges.
  logic prev_scl = 1'b1;
  int run_len = 0, hold_len = 0, fall_cnt = 0;
  bit seg_valid = 0, hold_arm = 0;
  always @(negedge clk) begin
    if (rst) begin
      seg_valid = 0; hold_arm = 0; run_len = 0; prev_scl = scl_out;
    end else begin
      if (hold_arm) begin
        hold_len++;
        if (sda_chg_stb) begin record(2, hold_len); hold_arm = 0; end
      end
      if (scl_out == prev_scl) run_len++;
      else begin
        if (seg_valid) record(prev_scl ? 1 : 0, run_len);
        seg_valid = 1; run_len = 1;
        if (!scl_out) begin
          hold_arm = 1; hold_len = 0; fall_cnt++;
          chk(scl_fall_stb == 1'b1, "R10 strobe on fall", scl_fall_stb, 1);
        end
      end
      if (scl_fall_stb && !(!scl_out && prev_scl))
        chk(1'b0, "R10 strobe without fall", 1, 0);
      if (scl_high_stb)
        chk(scl_filt == 1'b1, "R4 high count start needs filtered SCL", scl_filt, 1);
      prev_scl = scl_out;
    end
  end

  task automatic scenario(input logic [1:0] m, input int l, input int h, input int s,
                          input string tag);
    int lo_e, hi_e;
    item_t it;
    run = 0; rst = 1;
    speed_mode = m; spike_len = SPK_W'(l); sda_hold_cnt = HOLD_W'(h); stretch_cyc = s;
    repeat (3) @(negedge clk);
    rst = 0;
    cur_tag = tag;
    case (m)
      2'd1:    begin lo_e = int'(fast_lo); hi_e = int'(fast_hi); end
      2'd2:    begin lo_e = int'(hs_lo);   hi_e = int'(hs_hi);   end
      default: begin lo_e = int'(std_lo);  hi_e = int'(std_hi);  end
    endcase
    for (int p = 0; p < 3; p++) begin
      it.kind = 2; it.len = h + 1;            exp_q.push_back(it);
      it.kind = 0; it.len = lo_e + 1;         exp_q.push_back(it);
      if (p < 2) begin
        it.kind = 1; it.len = hi_e + l + 7 + s; exp_q.push_back(it);
      end
    end
    @(negedge clk) run = 1;
    while (exp_q.size() != 0) @(negedge clk);
    run = 0;
    repeat (40) @(negedge clk);
  endtask

  task automatic spike(input int l, input int w, input bit expect_drop);
    bit dropped = 0;
    @(negedge clk) sda_drv = 0;
    for (int i = 0; i < w + l + 8; i++) begin
      @(negedge clk);
      if (i == w - 1) sda_drv = 1;
      if (!sda_filt) dropped = 1;
    end
    chk(dropped == expect_drop, $sformatf("R5 glitch width %0d spike_len %0d", w, l),
        dropped, expect_drop);
    repeat (l + 6) @(negedge clk);
  endtask

  task automatic latency(input int l);
    spike_len = SPK_W'(l);
    repeat (4) @(negedge clk);
    sda_drv = 0;
    repeat (l + 2) @(posedge clk);
    @(negedge clk) chk(sda_filt == 1'b1, $sformatf("R6 early, spike_len %0d", l), sda_filt, 1);
    @(posedge clk);
    @(negedge clk) chk(sda_filt == 1'b0, $sformatf("R6 on time, spike_len %0d", l), sda_filt, 0);
    sda_drv = 1;
    repeat (l + 6) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual %0d expected %0d", 0, 1);
    summary();
    $finish;
  end

  initial begin
    int fc;
    repeat (3) @(negedge clk);
    chk(scl_out && !scl_fall_stb && !scl_high_stb && !sda_chg_stb && scl_filt && sda_filt,
        "R8 reset state", {scl_out, scl_fall_stb, scl_high_stb, sda_chg_stb, scl_filt, sda_filt},
        6'b100011);
    scenario(2'd0, 0, 2, 0,  "R1 mode0");
    scenario(2'd1, 1, 0, 0,  "R1 mode1");
    scenario(2'd2, 2, 1, 0,  "R1 mode2");
    scenario(2'd3, 0, 3, 0,  "R1 mode3");
    scenario(2'd0, 1, 2, 12, "R4 stretch");
    scenario(2'd1, 5, 4, 0,  "R3 long spike");
    // R9: with run low the clock stays released and no fall occurs.
    repeat (100) @(negedge clk);
    fc = fall_cnt;
    repeat (100) @(negedge clk);
    chk(fall_cnt == fc && scl_out, "R9 stopped", fall_cnt - fc, 0);
    // Filter tests on the data line, clock idle.
    spike_len = 8'd3;
    spike(3, 3, 0);
    spike(3, 4, 1);
    spike_len = 8'd0;
    spike(0, 1, 1);
    latency(0);
    latency(3);
    summary();
    $finish;
  end
endmodule